// File: doc/BRIEF.md
# Processor Low-Power State Controller

This controller sequences a processor core through its idle states. The platform asks for a target depth. The controller walks down one state per clock and raises the matching controls. It gates the core clocks, freezes the system-bus outputs, selects a reduced supply-voltage code and shrinks a set-associative last-level cache. Cache shrinking works by a per-way flush request and flush-done handshake. A way is switched off only after its contents are safe.

While clocks still run in stop-grant, snoops are serviced and interrupts are collected. However many interrupts arrive, only one is delivered when the core returns to normal operation. In sleep and the deeper states, snoops cannot be serviced; each one is flagged as an error pulse. A wake request or a pending interrupt climbs back up in reverse order, one state per clock. Voltage is restored before the clocks are re-enabled, and clocks return only once the regulator reports good.

Top module: `lps_ctrl`

## Requirements
- R1: After reset, state_o is 0 (run), clocks and bus are enabled, vsel_o is 00, every cache way is enabled, no flush is requested and the per-entry flush count is 1.
- R2: state_o codes are 0 run, 1 stop-grant, 2 stop-grant-snoop, 3 sleep, 4 deep sleep, 5 deeper sleep, 6 deeper sleep low-voltage, 7 enhanced deeper sleep. While req_i is high, the controller moves down one state per clock until it reaches the state selected by depth_i (1 stop-grant, 2 sleep, 3 deep sleep, 4 deeper sleep, 5 deeper sleep low-voltage). In stop-grant, clocks stay enabled.
- R3: Interrupts arriving outside run are latched into one pending flag. On return to run, irq_o pulses exactly once, one clock after state_o reaches 0. A pending interrupt does not end stop-grant.
- R4: A snoop in stop-grant enters stop-grant-snoop with snoop_busy_o high. The controller returns to stop-grant when snoop_done_i or irq_i is seen.
- R5: In sleep, clk_en_o is low and bus_en_o is high. A snoop in sleep or any deeper state produces a one-clock snoop_err_o pulse on the next clock and leaves state_o unchanged.
- R6: In deep sleep and below, bus_en_o is low.
- R7: Entering deeper sleep sets vsel_o to 01. It flushes the programmed number of still-enabled ways, lowest index first, with at most one flush request at a time. A way's enable drops only on the clock its flush_done_i is seen. A count of 0 flushes nothing.
- R8: In deeper sleep with depth 4 and no way left enabled, the controller enters enhanced deeper sleep (state 7) with vsel_o 11.
- R9: With depth 5, deeper sleep flushes every remaining way. It then enters state 6 with vsel_o 10, and all ways are disabled.
- R10: wake_i from sleep or below climbs 7→6→5→4→3 one state per clock. Voltage returns to 00 when leaving deeper sleep. The step from sleep to stop-grant waits for vgood_i. Stop-grant then goes to run on the next clock.
- R11: A pending interrupt in sleep or below starts the same climb as wake_i.
- R12: Disabled ways stay disabled through wake-up. way_set_i re-enables ways only while in run; outside run it has no effect.
- R13: cfg_we_i loads the per-entry flush count from cfg_cnt_i. Values above WAYS are clamped to WAYS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request to descend toward depth_i |
| depth_i | input | 3 | Target depth code |
| wake_i | input | 1 | Wake request |
| irq_i | input | 1 | Interrupt from system bus |
| snoop_i | input | 1 | Snoop request |
| snoop_done_i | input | 1 | Snoop service complete |
| vgood_i | input | 1 | Supply voltage at nominal |
| cfg_we_i | input | 1 | Flush count write strobe |
| cfg_cnt_i | input | CW | Flush count value |
| way_set_i | input | WAYS | Way re-enable mask |
| flush_done_i | input | WAYS | Per-way flush complete |
| state_o | output | 3 | Current state code |
| clk_en_o | output | 1 | Core clock enable |
| bus_en_o | output | 1 | Bus output activity enable |
| vsel_o | output | 2 | Voltage select code |
| snoop_busy_o | output | 1 | Snoop being serviced |
| snoop_err_o | output | 1 | Snoop not serviced pulse |
| irq_o | output | 1 | Delivered interrupt pulse |
| way_en_o | output | WAYS | Per-way enable |
| flush_req_o | output | WAYS | Per-way flush request |

## Verification
The assertions assume that flush_done_i is raised only for a way whose flush request is currently high. They also assume that vgood_i is a settled level rather than a glitch at the sleep-to-stop-grant step. The bench meets this with a responder that echoes flush_req_o into flush_done_i one half-clock later, and it changes vgood_i only on falling edges. Every stimulus is applied on a falling edge and held for whole clocks, so no request straddles a state change.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SG   = 3'd1,
    ST_SGS  = 3'd2,
    ST_SLP  = 3'd3,
    ST_DSLP = 3'd4,
    ST_DRS  = 3'd5,
    ST_DLV  = 3'd6,
    ST_EDS  = 3'd7
  } pwr_st_e;

  localparam logic [1:0] V_NOM = 2'b00;
  localparam logic [1:0] V_DRS = 2'b01;
  localparam logic [1:0] V_DLV = 2'b10;
  localparam logic [1:0] V_EDS = 2'b11;
endpackage

// File: rtl/lps_irq_latch.sv
module lps_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic irq_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else if (run_i) begin
      irq_o  <= pend_q | irq_i;
      pend_q <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (irq_i) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R3
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && run_i) |=> !pend_q);
endmodule

// File: rtl/lps_way_flush.sv
module lps_way_flush #(
  parameter int WAYS = 8,
  parameter int CW   = $clog2(WAYS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            set_ok_i,
  input  logic [WAYS-1:0] way_set_i,
  input  logic [WAYS-1:0] flush_done_i,
  output logic            busy_o,
  output logic [WAYS-1:0] way_en_o,
  output logic [WAYS-1:0] flush_req_o
);
  localparam int IW = $clog2(WAYS + 1);

  logic            busy_q;
  logic [IW-1:0]   idx_q;
  logic [CW-1:0]   rem_q;
  logic [WAYS-1:0] en_q;
  logic [WAYS-1:0] sel;
  logic            at_end, cur_en, req_act, hit;

  assign at_end  = (idx_q == IW'(WAYS));
  assign sel     = at_end ? '0 : (WAYS'(1) << idx_q);
  assign cur_en  = |(en_q & sel);
  assign req_act = busy_q && (rem_q != '0) && cur_en;
  assign hit     = req_act && |(flush_done_i & sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
      en_q   <= '1;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        rem_q  <= cnt_i;
      end else if (busy_q) begin
        if (rem_q == '0 || at_end) busy_q <= 1'b0;
        else if (!cur_en) idx_q <= idx_q + 1'b1;
        else if (hit) begin
          rem_q <= rem_q - 1'b1;
          idx_q <= idx_q + 1'b1;
        end
      end
      en_q <= (en_q & ~(hit ? sel : '0)) | (set_ok_i ? way_set_i : '0);
    end
  end

  assign busy_o      = busy_q;
  assign way_en_o    = en_q;
  assign flush_req_o = req_act ? sel : '0;

  // R7
  single_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flush_req_o));

  for (genvar w = 0; w < WAYS; w++) begin : g_drop
    // R7
    way_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_q[w]) |-> $past(flush_req_o[w] && flush_done_i[w]));
  end
endmodule

// File: rtl/lps_seq.sv
module lps_seq
  import lps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] depth_i,
  input  logic       wake_i,
  input  logic       pend_i,
  input  logic       irq_i,
  input  logic       snoop_i,
  input  logic       snoop_done_i,
  input  logic       vgood_i,
  input  logic       flush_busy_i,
  input  logic       ways_left_i,
  output logic       flush_start_o,
  output logic       flush_all_o,
  output logic [2:0] state_o,
  output logic       run_o,
  output logic       clk_en_o,
  output logic       bus_en_o,
  output logic [1:0] vsel_o,
  output logic       snoop_busy_o,
  output logic       snoop_err_o
);
  pwr_st_e st_q, st_n;
  logic    up_q, go_up, deep;

  assign deep  = (st_q >= ST_SLP);
  assign go_up = up_q | wake_i | pend_i;

  always_comb begin
    st_n          = st_q;
    flush_start_o = 1'b0;
    flush_all_o   = 1'b0;
    case (st_q)
      ST_RUN:  if (req_i && depth_i >= 3'd1) st_n = ST_SG;
      ST_SG: begin
        if (snoop_i)                        st_n = ST_SGS;
        else if (wake_i || up_q)            st_n = ST_RUN;
        else if (req_i && depth_i > 3'd1)   st_n = ST_SLP;
      end
      ST_SGS:  if (snoop_done_i || irq_i)   st_n = ST_SG;
      ST_SLP: begin
        if (go_up) begin
          if (vgood_i)                      st_n = ST_SG;
        end else if (req_i && depth_i > 3'd2) st_n = ST_DSLP;
      end
      ST_DSLP: begin
        if (go_up)                          st_n = ST_SLP;
        else if (req_i && depth_i > 3'd3) begin
          st_n          = ST_DRS;
          flush_start_o = 1'b1;
        end
      end
      ST_DRS: begin
        if (flush_busy_i)                   st_n = ST_DRS;
        else if (go_up)                     st_n = ST_DSLP;
        else if (req_i && depth_i > 3'd4) begin
          if (ways_left_i) begin
            flush_start_o = 1'b1;
            flush_all_o   = 1'b1;
          end else                          st_n = ST_DLV;
        end else if (!ways_left_i)          st_n = ST_EDS;
      end
      ST_DLV:  if (go_up)                   st_n = ST_DRS;
      ST_EDS:  if (go_up)                   st_n = ST_DLV;
      default:                              st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_RUN;
      up_q        <= 1'b0;
      snoop_err_o <= 1'b0;
    end else begin
      st_q        <= st_n;
      up_q        <= (st_n != ST_RUN) && (up_q || ((wake_i || pend_i) && deep));
      snoop_err_o <= snoop_i && deep;
    end
  end

  assign state_o      = st_q;
  assign run_o        = (st_q == ST_RUN);
  assign clk_en_o     = (st_q <= ST_SGS);
  assign bus_en_o     = (st_q <= ST_SLP);
  assign snoop_busy_o = (st_q == ST_SGS);
  always_comb begin
    case (st_q)
      ST_DRS:  vsel_o = V_DRS;
      ST_DLV:  vsel_o = V_DLV;
      ST_EDS:  vsel_o = V_EDS;
      default: vsel_o = V_NOM;
    endcase
  end

  // R10
  clk_after_vgood_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> $past(vgood_i));
  // R8
  eds_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EDS) |-> !ways_left_i);
  // R4
  sgs_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_SGS && st_q != ST_SGS) |-> $past(snoop_done_i || irq_i));
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl #(
  parameter int WAYS = 8,
  parameter int CW   = $clog2(WAYS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [2:0]      depth_i,
  input  logic            wake_i,
  input  logic            irq_i,
  input  logic            snoop_i,
  input  logic            snoop_done_i,
  input  logic            vgood_i,
  input  logic            cfg_we_i,
  input  logic [CW-1:0]   cfg_cnt_i,
  input  logic [WAYS-1:0] way_set_i,
  input  logic [WAYS-1:0] flush_done_i,
  output logic [2:0]      state_o,
  output logic            clk_en_o,
  output logic            bus_en_o,
  output logic [1:0]      vsel_o,
  output logic            snoop_busy_o,
  output logic            snoop_err_o,
  output logic            irq_o,
  output logic [WAYS-1:0] way_en_o,
  output logic [WAYS-1:0] flush_req_o
);
  logic [CW-1:0] cnt_q;
  logic          run, pend, fl_busy, fl_start, fl_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CW'(1);
    else if (cfg_we_i) cnt_q <= (cfg_cnt_i > CW'(WAYS)) ? CW'(WAYS) : cfg_cnt_i;
  end

  lps_irq_latch u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .irq_i(irq_i),
    .pend_o(pend), .irq_o(irq_o)
  );

  lps_way_flush #(.WAYS(WAYS), .CW(CW)) u_flush (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(fl_start),
    .cnt_i(fl_all ? CW'(WAYS) : cnt_q), .set_ok_i(run),
    .way_set_i(way_set_i), .flush_done_i(flush_done_i),
    .busy_o(fl_busy), .way_en_o(way_en_o), .flush_req_o(flush_req_o)
  );

  lps_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .depth_i(depth_i),
    .wake_i(wake_i), .pend_i(pend), .irq_i(irq_i), .snoop_i(snoop_i),
    .snoop_done_i(snoop_done_i), .vgood_i(vgood_i),
    .flush_busy_i(fl_busy), .ways_left_i(|way_en_o),
    .flush_start_o(fl_start), .flush_all_o(fl_all),
    .state_o(state_o), .run_o(run), .clk_en_o(clk_en_o),
    .bus_en_o(bus_en_o), .vsel_o(vsel_o),
    .snoop_busy_o(snoop_busy_o), .snoop_err_o(snoop_err_o)
  );
endmodule

// File: tb/lps_ctrl_test.sv
module lps_ctrl_test;
  localparam int PERIOD = 10;
  localparam int WAYS   = 8;
  localparam int CW     = $clog2(WAYS + 1);

  logic clk = 0, rst_n = 0;
  logic req = 0, wake = 0, irq = 0, snoop = 0, snoop_done = 0, vgood = 1, cfg_we = 0;
  logic [2:0] depth = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic [WAYS-1:0] way_set = 0, fdone = 0;
  logic [2:0] state;
  logic clk_en, bus_en, snoop_busy, snoop_err, irq_o;
  logic [1:0] vsel;
  logic [WAYS-1:0] way_en, freq;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  lps_ctrl #(.WAYS(WAYS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .depth_i(depth), .wake_i(wake),
    .irq_i(irq), .snoop_i(snoop), .snoop_done_i(snoop_done), .vgood_i(vgood),
    .cfg_we_i(cfg_we), .cfg_cnt_i(cfg_cnt), .way_set_i(way_set),
    .flush_done_i(fdone), .state_o(state), .clk_en_o(clk_en), .bus_en_o(bus_en),
    .vsel_o(vsel), .snoop_busy_o(snoop_busy), .snoop_err_o(snoop_err),
    .irq_o(irq_o), .way_en_o(way_en), .flush_req_o(freq)
  );

  always @(negedge clk) fdone <= freq;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(input int exp, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (state == 3'(exp)) break;
      @(negedge clk);
    end
  endtask

  task automatic count_irq(input string tag, input int exp);
    int c = 0;
    for (int i = 0; i < 4; i++) begin
      if (irq_o) c++;
      @(negedge clk);
    end
    chk(tag, c, exp);
  endtask

  task automatic set_cnt(input int v);
    cfg_cnt = CW'(v); cfg_we = 1; cyc(1); cfg_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 bus_en", bus_en, 1);
    chk("R1 vsel", vsel, 0);
    chk("R1 way_en", way_en, 8'hFF);
    chk("R1 flush_req", freq, 0);
  endtask

  task automatic t_stop_grant;
    req = 1; depth = 1; cyc(1);
    chk("R2 enter stop-grant", state, 1);
    chk("R2 clocks on in stop-grant", clk_en, 1);
    req = 0;
    for (int i = 0; i < 3; i++) begin irq = 1; cyc(1); irq = 0; cyc(1); end
    chk("R3 pending irq keeps stop-grant", state, 1);
    chk("R3 no irq_o in stop-grant", irq_o, 0);
    snoop = 1; cyc(1); snoop = 0;
    chk("R4 snoop state", state, 2);
    chk("R4 snoop busy", snoop_busy, 1);
    cyc(2);
    chk("R4 waits for snoop done", state, 2);
    snoop_done = 1; cyc(1); snoop_done = 0;
    chk("R4 back to stop-grant", state, 1);
    snoop = 1; cyc(1); snoop = 0;
    irq = 1; cyc(1); irq = 0;
    chk("R4 irq ends snoop state", state, 1);
    wake = 1; cyc(1); wake = 0;
    chk("R3 back to run", state, 0);
    count_irq("R3 single delivered irq", 1);
  endtask

  task automatic t_sleep;
    req = 1; depth = 2; cyc(2);
    chk("R2 one step per clock to sleep", state, 3);
    chk("R5 clocks off", clk_en, 0);
    chk("R5 bus on", bus_en, 1);
    snoop = 1; cyc(1); snoop = 0;
    chk("R5 snoop error pulse", snoop_err, 1);
    chk("R5 state unchanged", state, 3);
    cyc(1);
    chk("R5 error pulse one clock", snoop_err, 0);
    depth = 3; cyc(1);
    chk("R6 deep sleep", state, 4);
    chk("R6 bus off", bus_en, 0);
    req = 0; vgood = 0; wake = 1; cyc(1); wake = 0;
    chk("R10 climb to sleep", state, 3);
    cyc(5);
    chk("R10 holds for vgood", state, 3);
    chk("R10 clocks stay off", clk_en, 0);
    vgood = 1; cyc(1);
    chk("R10 stop-grant after vgood", state, 1);
    cyc(1);
    chk("R10 run", state, 0);
  endtask

  task automatic descend4;
    req = 1; depth = 4;
    wait_state(5, 20);
    chk("R7 in deeper sleep", state, 5);
    chk("R7 vsel deeper", vsel, 1);
    cyc(WAYS + 4);
  endtask

  task automatic climb;
    req = 0; wake = 1; cyc(1); wake = 0;
    wait_state(0, 30);
  endtask

  task automatic t_deeper;
    set_cnt(3);
    descend4;
    chk("R7 three lowest ways flushed", way_en, 8'hF8);
    chk("R7 stays deeper", state, 5);
    way_set = 8'hFF; cyc(1); way_set = 0; cyc(1);
    chk("R12 set ignored outside run", way_en, 8'hF8);
    climb;
    chk("R12 ways stay off after wake", way_en, 8'hF8);
    descend4;
    chk("R7 next three ways", way_en, 8'hC0);
    climb;
    descend4;
    chk("R8 all ways flushed", way_en, 0);
    chk("R8 enhanced state", state, 7);
    chk("R8 enhanced vsel", vsel, 3);
    req = 0; wake = 1; cyc(1); wake = 0;
    chk("R10 step 6", state, 6);
    chk("R10 vsel 10", vsel, 2);
    cyc(1); chk("R10 step 5", state, 5);
    cyc(1); chk("R10 step 4", state, 4);
    chk("R10 voltage nominal before clocks", vsel, 0);
    cyc(1); chk("R10 step 3", state, 3);
    cyc(1); chk("R10 step 1", state, 1);
    cyc(1); chk("R10 step 0", state, 0);
    way_set = 8'hFF; cyc(1); way_set = 0;
    chk("R12 re-enable in run", way_en, 8'hFF);
  endtask

  task automatic t_zero_and_lv;
    set_cnt(0);
    descend4;
    chk("R7 count zero flushes none", way_en, 8'hFF);
    chk("R7 count zero stays deeper", state, 5);
    climb;
    set_cnt(2);
    req = 1; depth = 5;
    wait_state(6, 40);
    chk("R9 low-voltage state", state, 6);
    chk("R9 vsel 10", vsel, 2);
    chk("R9 all ways off", way_en, 0);
    req = 0; irq = 1; cyc(1); irq = 0;
    wait_state(0, 30);
    chk("R11 irq wakes", state, 0);
    count_irq("R11 irq delivered once", 1);
    way_set = 8'hFF; cyc(1); way_set = 0;
  endtask

  task automatic t_clamp;
    set_cnt(15);
    descend4;
    chk("R13 clamp flushes all", way_en, 0);
    chk("R13 enhanced after clamp", state, 7);
    climb;
    chk("R13 back to run", state, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(2);
    t_reset;
    rst_n = 1;
    cyc(1);
    t_reset;
    t_stop_grant;
    t_sleep;
    t_deeper;
    t_zero_and_lv;
    t_clamp;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule